// File: doc/BRIEF.md
# Dirty Rectangle Redraw Ring Queue

This block keeps a circular list of screen regions that drawing engines have changed and that still have to be shown. Each region is one rectangle given by a corner (x, y), a width and a height. A drawing engine pushes a rectangle in a single cycle, and a push is never refused. When the ring fills up, the write pointer keeps going and writes over the oldest entries.

A flush request starts a drain. The pending rectangles leave the block oldest first, on a valid/ready output port that feeds a display updater. A flush request made while the full-screen invalidate input is high works differently. It discards every pending rectangle in one cycle and outputs none of them, because the whole screen will be redrawn in any case.

Top module: `dirty_rect_ring`

## Requirements
- R1: After reset, empty_o is 1, flush_busy_o is 0 and out_valid_o is 0.
- R2: A push cycle stores {x, y, w, h} at the write slot and advances the write pointer. A push into an empty queue makes empty_o low from the next cycle on.
- R3: A flush with invalidate_i low outputs the pending rectangles in the order they were pushed. out_valid_o rises in the cycle after the flush cycle.
- R4: The read pointer advances only when out_valid_o and out_ready_i are both high. While out_ready_i is low, the same rectangle is held with out_valid_o high. The next rectangle appears in the cycle after an accepted transfer.
- R5: A flush cycle with invalidate_i high makes the read pointer equal to the write pointer. From the next cycle on, empty_o is 1, flush_busy_o is 0, and the discarded rectangles are never output.
- R6: flush_busy_o rises in the cycle after a flush without invalidate. It stays high until the cycle after the queue becomes empty, then falls.
- R7: A push and an accepted transfer in the same cycle both take effect. A rectangle pushed during a drain is output after the ones already pending.
- R8: There is no full check. A push always writes, and pointers wrap modulo DEPTH, which must be a power of two. After exactly DEPTH pushes with no pop, empty_o is 1. After DEPTH+k pushes, a flush outputs only the k newest rectangles.
- R9: A flush of an empty queue raises flush_busy_o for one cycle and outputs nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| push_i | input | 1 | Store one rectangle this cycle |
| push_x_i | input | CW | Left coordinate of the pushed rectangle |
| push_y_i | input | CW | Top coordinate of the pushed rectangle |
| push_w_i | input | CW | Width of the pushed rectangle |
| push_h_i | input | CW | Height of the pushed rectangle |
| flush_i | input | 1 | Flush request, one cycle |
| invalidate_i | input | 1 | Full-screen invalidate; turns a flush into a discard |
| out_valid_o | output | 1 | A rectangle is offered |
| out_ready_i | input | 1 | Downstream accepts the offered rectangle |
| out_x_o | output | CW | Left coordinate of the offered rectangle |
| out_y_o | output | CW | Top coordinate of the offered rectangle |
| out_w_o | output | CW | Width of the offered rectangle |
| out_h_o | output | CW | Height of the offered rectangle |
| flush_busy_o | output | 1 | A drain is in progress |
| empty_o | output | 1 | Read and write pointers are equal |

## Verification
Pointers and the busy flag are single registers, and the offered rectangle is read combinationally at the read pointer. Every result is therefore due one clock edge after its cause: empty_o after a push or discard, out_valid_o and flush_busy_o after a flush, and the next rectangle after an accepted transfer. The bench drives inputs and samples outputs on the falling edge. It checks each result at the first falling edge after the rising edge that produces it. flush_busy_o is checked once more one cycle later, where the drain ends.

// File: rtl/dirty_rect_ring.sv
module dirty_rect_ring #(
  parameter int DEPTH = 512,
  parameter int CW    = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push_i,
  input  logic [CW-1:0] push_x_i,
  input  logic [CW-1:0] push_y_i,
  input  logic [CW-1:0] push_w_i,
  input  logic [CW-1:0] push_h_i,
  input  logic          flush_i,
  input  logic          invalidate_i,
  output logic          out_valid_o,
  input  logic          out_ready_i,
  output logic [CW-1:0] out_x_o,
  output logic [CW-1:0] out_y_o,
  output logic [CW-1:0] out_w_o,
  output logic [CW-1:0] out_h_o,
  output logic          flush_busy_o,
  output logic          empty_o
);
  localparam int AW = $clog2(DEPTH);
  localparam int EW = 4 * CW;

  generate
    if ((DEPTH & (DEPTH - 1)) != 0 || DEPTH < 2) begin : g_bad_depth
      $error("DEPTH must be a power of two");
    end
  endgenerate

  logic [EW-1:0] slots [DEPTH];
  logic [AW-1:0] wr_q, rd_q;
  logic          busy_q;

  wire discard = flush_i & invalidate_i;
  wire pop     = out_valid_o & out_ready_i;

  assign empty_o      = (rd_q == wr_q);
  assign flush_busy_o = busy_q;
  assign out_valid_o  = busy_q & ~empty_o;
  assign {out_x_o, out_y_o, out_w_o, out_h_o} = slots[rd_q];

  always_ff @(posedge clk) begin
    if (push_i) slots[wr_q] <= {push_x_i, push_y_i, push_w_i, push_h_i};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q <= '0;
      rd_q <= '0;
    end else begin
      if (push_i)       wr_q <= wr_q + 1'b1;
      if (discard)      rd_q <= wr_q;
      else if (pop)     rd_q <= rd_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                         busy_q <= 1'b0;
    else if (discard)                   busy_q <= 1'b0;
    else if (flush_i)                   busy_q <= 1'b1;
    else if (busy_q && empty_o && !push_i) busy_q <= 1'b0;
  end

  AST_PUSH_FILLS: assert property (@(posedge clk) disable iff (!rst_n)
    push_i && empty_o |=> !empty_o); // R2
  AST_HOLD_UNTIL_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid_o && !out_ready_i && !flush_i && !push_i |=>
      out_valid_o && $stable(out_x_o) && $stable(out_y_o) && $stable(out_w_o) && $stable(out_h_o)); // R4
  AST_DISCARD_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    discard && !push_i |=> empty_o && !flush_busy_o && !out_valid_o); // R5
  AST_BUSY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    flush_busy_o && !empty_o && !discard |=> flush_busy_o); // R6
  AST_PUSH_POP_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
    push_i && pop && !flush_i |=> !empty_o); // R7
endmodule

// File: tb/dirty_rect_ring_tb_top.sv
`timescale 1ns/1ps
module dirty_rect_ring_tb_top;
  localparam int DEPTH = 512;
  localparam int CW = 12;

  logic clk = 1'b0, rst_n = 1'b0;
  logic push_i = 0, flush_i = 0, invalidate_i = 0, out_ready_i = 0;
  logic [CW-1:0] px = 0, py = 0, pw = 0, ph = 0;
  logic out_valid_o, flush_busy_o, empty_o;
  logic [CW-1:0] ox, oy, ow, oh;
  int n_chk = 0, n_bad = 0;
  logic [4*CW-1:0] expq [$];

  always #2.5 clk = ~clk;

  dirty_rect_ring #(.DEPTH(DEPTH), .CW(CW)) dut_i (
    .clk(clk), .rst_n(rst_n), .push_i(push_i),
    .push_x_i(px), .push_y_i(py), .push_w_i(pw), .push_h_i(ph),
    .flush_i(flush_i), .invalidate_i(invalidate_i),
    .out_valid_o(out_valid_o), .out_ready_i(out_ready_i),
    .out_x_o(ox), .out_y_o(oy), .out_w_o(ow), .out_h_o(oh),
    .flush_busy_o(flush_busy_o), .empty_o(empty_o));

  function automatic logic [4*CW-1:0] rect_of(int i);
    return {CW'(i), CW'(i + 7), CW'(i * 3 + 1), CW'(i ^ 5)};
  endfunction

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic push_one(int i);
    {px, py, pw, ph} = rect_of(i);
    push_i = 1;
    @(negedge clk);
    push_i = 0;
  endtask

  task automatic flush_pulse(bit inv);
    flush_i = 1; invalidate_i = inv;
    @(negedge clk);
    flush_i = 0; invalidate_i = 0;
  endtask

  task automatic drain(bit stall);
    logic [4*CW-1:0] held;
    bit was_held = 0;
    flush_pulse(0);
    chk("R6 busy after flush", flush_busy_o, 1);
    for (int c = 0; c < 400 && expq.size() > 0; c++) begin
      out_ready_i = stall ? ((c % 3) == 2) : 1'b1;
      chk("R3 valid while pending", out_valid_o, 1);
      if (was_held) chk("R4 held rect", {ox, oy, ow, oh}, held);
      if (out_ready_i) begin
        chk("R3 order", {ox, oy, ow, oh}, expq.pop_front());
        was_held = 0;
      end else begin
        held = {ox, oy, ow, oh};
        was_held = 1;
      end
      @(negedge clk);
    end
    out_ready_i = 0;
    chk("R4 no valid after last", out_valid_o, 0);
    chk("R6 busy one cycle past empty", flush_busy_o, 1);
    @(negedge clk);
    chk("R6 busy falls", flush_busy_o, 0);
    chk("R6 empty", empty_o, 1);
  endtask

  task automatic t_reset;
    chk("R1 empty", empty_o, 1);
    chk("R1 busy", flush_busy_o, 0);
    chk("R1 valid", out_valid_o, 0);
  endtask

  task automatic t_basic(bit stall, int base);
    for (int i = 0; i < 5; i++) begin
      push_one(base + i);
      expq.push_back(rect_of(base + i));
      chk("R2 nonempty after push", empty_o, 0);
    end
    drain(stall);
  endtask

  task automatic t_discard;
    for (int i = 0; i < 4; i++) push_one(100 + i);
    flush_pulse(1);
    chk("R5 empty", empty_o, 1);
    chk("R5 busy", flush_busy_o, 0);
    for (int i = 0; i < 3; i++) begin
      chk("R5 no output", out_valid_o, 0);
      @(negedge clk);
    end
  endtask

  task automatic t_empty_flush;
    flush_pulse(0);
    chk("R9 busy pulse", flush_busy_o, 1);
    chk("R9 no valid", out_valid_o, 0);
    @(negedge clk);
    chk("R9 busy low", flush_busy_o, 0);
    chk("R9 no valid later", out_valid_o, 0);
  endtask

  task automatic t_push_during_drain;
    push_one(200); push_one(201);
    flush_pulse(0);
    out_ready_i = 1;
    chk("R7 first", {ox, oy, ow, oh}, rect_of(200));
    {px, py, pw, ph} = rect_of(202);
    push_i = 1;
    @(negedge clk);
    push_i = 0;
    chk("R7 second", {ox, oy, ow, oh}, rect_of(201));
    chk("R7 valid", out_valid_o, 1);
    @(negedge clk);
    chk("R7 pushed in drain", {ox, oy, ow, oh}, rect_of(202));
    chk("R7 valid late", out_valid_o, 1);
    @(negedge clk);
    out_ready_i = 0;
    chk("R7 done", out_valid_o, 0);
    @(negedge clk);
    chk("R7 busy low", flush_busy_o, 0);
  endtask

  task automatic t_overflow;
    for (int i = 0; i < DEPTH; i++) push_one(1000 + i);
    chk("R8 wrapped to empty", empty_o, 1);
    for (int i = 0; i < 3; i++) begin
      push_one(1000 + DEPTH + i);
      expq.push_back(rect_of(1000 + DEPTH + i));
    end
    drain(0);
  endtask

  initial begin
    #(100000 * 5);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_basic(0, 10);
    t_basic(1, 40);
    t_discard();
    t_empty_flush();
    t_push_during_drain();
    t_overflow();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule